// File: doc/BRIEF.md
# Gate Permit and Die-Temperature Supervisor

This block decides, every clock cycle, whether a synchronous-buck half-bridge driver is allowed to switch. It also tells the rest of the chip about the die temperature. Three things must all be true for the gate sequencer to be allowed to switch:

- the supply comparator reports a good supply;
- the external disable input is actively driven high and has stayed high for a programmable settling interval;
- no thermal trip is in force.

A pin that is not driven (open) is treated the same as a low pin.

Two independent hysteretic comparators watch an unsigned die-temperature code in degrees Celsius. The first drives an active-low warning output and never stops switching. The second is the trip comparator, and it withholds the gate permit until the die has cooled well below the trip point. Each time the disable input goes from not-high to high, the block emits a single-cycle pulse. This pulse starts an auto-calibration of the zero-cross comparator threshold.

Top module: `gate_permit_supervisor`

## Requirements
- R1: While `supply_ok` is low, `gate_en` is low in the same cycle, whatever the disable input and temperature are.
- R2: The disable input counts as high only when `dis_driven` is 1 and `dis_level` is 1. An open pin (`dis_driven` = 0) or a driven low level forces `gate_en` low in the same cycle, with no clock edge needed.
- R3: After the disable input becomes high, `gate_en` goes high right after the `EN_DELAY_CYC`-th consecutive rising clock edge at which the input was sampled high. This holds provided the supply is good and no trip is active.
- R4: If the disable input leaves the high state before the settling count completes, the count starts over. A full `EN_DELAY_CYC` high edges are needed again.
- R5: `warn_n` goes low after the first rising edge at which `temp_code` is 150 or more.
- R6: Once active, the warning is cleared (`warn_n` high) only after an edge that samples `temp_code` of 135 or less. Codes from 136 to 149 leave it unchanged.
- R7: The warning state has no effect on `gate_en`.
- R8: After a rising edge that samples `temp_code` of 180 or more, the trip is active and `gate_en` is low.
- R9: The trip is released only after an edge that samples `temp_code` of 155 or less. Codes from 156 to 179 keep it in force.
- R10: `cal_start` is high for exactly one cycle, in the cycle after the first rising edge that samples the disable input high following a sample where it was low or open. At no other time is it high.
- R11: During and directly after reset, `gate_en` is 0, `warn_n` is 1 and `cal_start` is 0. The warning and trip states are cleared, and the settling count is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| supply_ok | input | 1 | Undervoltage comparator: 1 = supply above threshold |
| dis_level | input | 1 | Logic level seen on the disable input |
| dis_driven | input | 1 | 1 = the disable input is actively driven, 0 = open |
| temp_code | input | TEMP_W | Die temperature, unsigned, degrees Celsius |
| gate_en | output | 1 | Permit for the gate sequencer to switch |
| warn_n | output | 1 | Thermal warning, active low |
| cal_start | output | 1 | One-cycle trigger for zero-cross threshold calibration |

## Verification
Two pairs of functions can act in the same cycle. In the first, a trip can set, or be released, in the very cycle that the settling count completes. In the second, the warning and the trip comparators can both change on one temperature step. The random phase provokes both. Its temperature random walk crosses 135, 150, 155 and 180 while the disable input toggles, so some trip edges land exactly on the cycle where the count saturates. Some temperature jumps also cross both set points at once. Each cycle, a bench model built from the rules above judges all three outputs together, so the trip's veto on a newly ready permit is checked. So is the independence of the warning from the permit.

// File: rtl/gps_pkg.sv
package gps_pkg;

  // Decoded view of the disable input.
  typedef enum logic [1:0] {
    PIN_OPEN = 2'd0,
    PIN_LOW  = 2'd1,
    PIN_HIGH = 2'd2
  } pin_state_e;

  function automatic pin_state_e decode_pin(input logic driven, input logic level);
    if (!driven)    return PIN_OPEN;
    else if (level) return PIN_HIGH;
    else            return PIN_LOW;
  endfunction

  // Set comparison: temperature at or above the threshold.
  function automatic logic reached(input int unsigned t, input int unsigned thr);
    return t >= thr;
  endfunction

  // Clear comparison: temperature has dropped hys below thr (no underflow).
  function automatic logic cooled(input int unsigned t, input int unsigned thr,
                                  input int unsigned hys);
    return (t + hys) <= thr;
  endfunction

endpackage

// File: rtl/hyst_flag.sv
module hyst_flag #(
  parameter int TEMP_W = 8,
  parameter int SET_AT = 150,
  parameter int HYS    = 15
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [TEMP_W-1:0] level,
  output logic              flag,
  output logic              set_hit,
  output logic              clr_hit
);
  import gps_pkg::*;

  localparam int unsigned SET_U = SET_AT;
  localparam int unsigned HYS_U = HYS;

  assign set_hit = reached(int'(level), SET_U);
  assign clr_hit = cooled(int'(level), SET_U, HYS_U);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       flag <= 1'b0;
    else if (set_hit) flag <= 1'b1;
    else if (clr_hit) flag <= 1'b0;
  end

  // Set side: a sample at/above threshold raises the flag on the next cycle.
  a_r5_r8_flag_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(level) >= SET_AT) |=> flag);

  // Clear side: a sample within HYS of the threshold leaves the flag unchanged.
  a_r6_r9_flag_holds: assert property (@(posedge clk) disable iff (!rst_n)
    ((int'(level) < SET_AT) && (int'(level) + HYS > SET_AT)) |=> $stable(flag));

  a_r6_r9_flag_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(level) + HYS <= SET_AT) |=> !flag);

endmodule

// File: rtl/enable_timer.sv
module enable_timer #(
  parameter int DELAY = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_hi,
  output logic ready,
  output logic pin_rise,
  output logic cal_pulse
);
  localparam int CW = $clog2(DELAY + 1);
  localparam logic [CW-1:0] LIM = CW'(DELAY);

  logic [CW-1:0] cnt;
  logic          pin_q;

  assign pin_rise = pin_hi & ~pin_q;
  assign ready    = (cnt == LIM);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt       <= '0;
      pin_q     <= 1'b0;
      cal_pulse <= 1'b0;
    end else begin
      pin_q     <= pin_hi;
      cal_pulse <= pin_rise;
      if (!pin_hi)         cnt <= '0;
      else if (cnt != LIM) cnt <= cnt + 1'b1;
    end
  end

  // The settling count restarts whenever the input is sampled not-high.
  a_r4_count_restarts: assert property (@(posedge clk) disable iff (!rst_n)
    !pin_hi |=> (cnt == '0));

  // Readiness can only follow a cycle in which the input was high.
  a_r3_ready_after_high: assert property (@(posedge clk) disable iff (!rst_n)
    ready |-> $past(pin_hi));

  // The calibration trigger lasts a single cycle.
  a_r10_pulse_single: assert property (@(posedge clk) disable iff (!rst_n)
    cal_pulse |=> !cal_pulse);

  a_r10_pulse_after_rise: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cal_pulse) |-> $past(pin_hi));

endmodule

// File: rtl/gate_permit_supervisor.sv
module gate_permit_supervisor #(
  parameter int TEMP_W       = 8,
  parameter int WARN_AT      = 150,
  parameter int WARN_HYS     = 15,
  parameter int TRIP_AT      = 180,
  parameter int TRIP_HYS     = 25,
  parameter int EN_DELAY_CYC = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              supply_ok,
  input  logic              dis_level,
  input  logic              dis_driven,
  input  logic [TEMP_W-1:0] temp_code,
  output logic              gate_en,
  output logic              warn_n,
  output logic              cal_start
);
  import gps_pkg::*;

  pin_state_e pin_st;
  logic       pin_hi;
  logic       settled;
  logic       pin_rise;
  logic       warn_act, warn_set_hit, warn_clr_hit;
  logic       trip_act, trip_set_hit, trip_clr_hit;

  assign pin_st = decode_pin(dis_driven, dis_level);
  assign pin_hi = (pin_st == PIN_HIGH);

  enable_timer #(.DELAY(EN_DELAY_CYC)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .pin_hi   (pin_hi),
    .ready    (settled),
    .pin_rise (pin_rise),
    .cal_pulse(cal_start)
  );

  hyst_flag #(.TEMP_W(TEMP_W), .SET_AT(WARN_AT), .HYS(WARN_HYS)) u_warn (
    .clk    (clk),
    .rst_n  (rst_n),
    .level  (temp_code),
    .flag   (warn_act),
    .set_hit(warn_set_hit),
    .clr_hit(warn_clr_hit)
  );

  hyst_flag #(.TEMP_W(TEMP_W), .SET_AT(TRIP_AT), .HYS(TRIP_HYS)) u_trip (
    .clk    (clk),
    .rst_n  (rst_n),
    .level  (temp_code),
    .flag   (trip_act),
    .set_hit(trip_set_hit),
    .clr_hit(trip_clr_hit)
  );

  // Disable and supply paths are combinational to the permit.
  assign gate_en = supply_ok & pin_hi & settled & ~trip_act;
  assign warn_n  = ~warn_act;

  // A hot sample blocks the permit on the following cycle.
  a_r8_trip_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(temp_code) >= TRIP_AT) |=> !gate_en);

  // The permit can only rise once the input has been high on the previous edge.
  a_r3_permit_needs_history: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(gate_en) |-> $past(pin_hi));

  // The calibration trigger follows a rise of the decoded input.
  a_r10_cal_follows_rise: assert property (@(posedge clk) disable iff (!rst_n)
    cal_start |-> $past(pin_rise));

endmodule

// File: tb/sim_gate_permit_supervisor.sv
`timescale 1ns/1ps
module sim_gate_permit_supervisor;

  localparam int DLY = 16;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       supply_ok, dis_level, dis_driven;
  logic [7:0] temp_code;
  logic       gate_en, warn_n, cal_start;

  always #2.5 clk = ~clk;

  gate_permit_supervisor #(.EN_DELAY_CYC(DLY)) u0 (
    .clk(clk), .rst_n(rst_n), .supply_ok(supply_ok), .dis_level(dis_level),
    .dis_driven(dis_driven), .temp_code(temp_code),
    .gate_en(gate_en), .warn_n(warn_n), .cal_start(cal_start)
  );

  int  checks = 0;
  int  errors = 0;
  bit  done   = 0;

  // Bench model state.
  int  m_hi_run;
  bit  m_prev, m_cal, m_warn, m_trip;

  function automatic bit exp_gate();
    bit pin = dis_driven && dis_level;
    return supply_ok && pin && (m_hi_run >= DLY) && !m_trip;
  endfunction

  task automatic model_edge();
    bit pin = dis_driven && dis_level;
    int t = int'(temp_code);
    m_cal = pin && !m_prev;
    m_prev = pin;
    if (!pin) m_hi_run = 0;
    else if (m_hi_run < DLY) m_hi_run++;
    if (t > 149) m_warn = 1; else if (t < 136) m_warn = 0;
    if (t > 179) m_trip = 1; else if (t < 156) m_trip = 0;
  endtask

  task automatic model_clear();
    m_hi_run = 0; m_prev = 0; m_cal = 0; m_warn = 0; m_trip = 0;
  endtask

  task automatic apply(input bit s, input bit lvl, input bit drv, input int t);
    @(negedge clk);
    supply_ok = s; dis_level = lvl; dis_driven = drv; temp_code = 8'(t);
    @(posedge clk);
    #1;
    model_edge();
  endtask

  task automatic check(input string req);
    bit eg = exp_gate();
    checks++;
    if (gate_en !== eg || warn_n !== !m_warn || cal_start !== m_cal) begin
      errors++;
      $display("FAIL %s: gate_en=%b warn_n=%b cal_start=%b expected %b %b %b",
               req, gate_en, warn_n, cal_start, eg, !m_warn, m_cal);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not end, expected completion");
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int t;
    void'($urandom(32'h1A2B3C));
    rst_n = 0; supply_ok = 1; dis_level = 1; dis_driven = 1; temp_code = 8'd200;
    model_clear();
    repeat (3) @(posedge clk);
    #1 check("R11 in reset");
    @(negedge clk) rst_n = 1;
    #1 check("R11 after reset");

    // First rise: calibration pulse then full settling interval (R10, R3).
    apply(1, 0, 1, 25); check("R10 low");
    apply(1, 1, 1, 25); check("R10 pulse");
    for (int i = 1; i < DLY + 3; i++) begin apply(1, 1, 1, 25); check("R3 settle"); end

    // Open and low inputs (R2).
    apply(1, 1, 0, 25); check("R2 open");
    apply(1, 0, 1, 25); check("R2 low");
    apply(1, 1, 0, 25); check("R2 open again");

    // Interrupted settling restarts (R4).
    for (int i = 0; i < 10; i++) begin apply(1, 1, 1, 25); check("R4 partial"); end
    apply(1, 0, 1, 25); check("R4 drop");
    for (int i = 0; i < DLY + 2; i++) begin apply(1, 1, 1, 25); check("R4 restart"); end

    // Supply gating (R1).
    apply(0, 1, 1, 25); check("R1 supply low");
    apply(1, 1, 1, 25); check("R1 supply back");

    // Warning set, hold, clear; permit unaffected (R5, R6, R7).
    apply(1, 1, 1, 149); check("R5 below");
    apply(1, 1, 1, 150); check("R5 set");
    apply(1, 1, 1, 170); check("R7 warn no effect");
    apply(1, 1, 1, 136); check("R6 hold");
    apply(1, 1, 1, 135); check("R6 clear");

    // Trip set, hold, release (R8, R9).
    apply(1, 1, 1, 179); check("R8 below");
    apply(1, 1, 1, 180); check("R8 trip");
    apply(1, 1, 1, 156); check("R9 hold");
    apply(1, 1, 1, 155); check("R9 release");
    apply(1, 1, 1, 255); check("R8 max code");
    apply(1, 1, 1, 0);   check("R9 cold");

    // Constrained random: temperature walk across all thresholds.
    t = 140;
    for (int i = 0; i < 6000; i++) begin
      bit s   = ($urandom_range(0, 19) != 0);
      bit drv = ($urandom_range(0, 24) != 0);
      bit lvl = (i % 97 < 70) ? ($urandom_range(0, 39) != 0) : ($urandom_range(0, 1) == 1);
      t = t + $urandom_range(0, 10) - 5;
      if ($urandom_range(0, 63) == 0) t = $urandom_range(120, 200);
      if (t < 100) t = 100;
      if (t > 210) t = 210;
      apply(s, lvl, drv, t);
      check("R1..R10 random");
    end

    done = 1;
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule